// File: doc/BRIEF.md
# Memory Type Range Resolver

This block holds a set of memory-type range registers and turns a 36-bit physical address into the memory type that applies to it. Software programs the registers through a 64-bit port addressed by a small index. Behind that port sit a read-only capability word, a default-type word, a bank of fixed-range registers and pairs of base and mask words for the variable ranges.

Addresses in the first megabyte can take their type from the fixed bank. Each fixed register packs eight one-byte type codes, one for each small region. Every other address is compared against the variable ranges, and overlapping hits are settled by a precedence rule. When nothing matches, the default type applies.

The block also raises two configuration flags. One marks a variable range whose shape is illegal. The other marks two ranges that overlap with types that must not share memory.

Type codes used throughout: 0 uncacheable, 1 write-combining, 4 write-through, 5 write-protect, 6 write-back.

Top module: `mtr_unit`

## Requirements
- R1: While reset is held and right after it, `memType` is 0, both configuration flags are 0, and the default, fixed and variable words all read back as 0.
- R2: Index 0 reads as the capability word: bits [7:0] hold NUM_VAR and bit 8 holds FIX_SUP. Writes to index 0 change nothing.
- R3: The write index map is as follows. Index 1 is the default word, which keeps bit 11 (global enable), bit 10 (fixed enable) and bits [7:0] (default type). Indices 2 to 12 are the eleven fixed words, stored whole. Index 16+2k is the base word of range k, which keeps [35:12] and [7:0]. Index 17+2k is the mask word of range k, which keeps bit 11 (valid) and [35:12]. Bits a word does not keep read as 0. A write is visible on `rdData` after the next rising edge.
- R4: When the global enable is 0, the resolved type is 0 whatever the other words hold.
- R5: The fixed enable applies only when FIX_SUP is 1. With it set, an address below 0x100000 takes its type from the fixed bank. Regions are numbered upward by address: 0 to 7 are 64 KiB each from 0; 8 to 23 are 16 KiB each from 0x80000; 24 to 87 are 4 KiB each from 0xC0000. Region r is byte r%8 (bits [8*(r%8)+7 : 8*(r%8)]) of fixed word r/8.
- R6: With the fixed enable clear, an address below 0x100000 is resolved like any other address, through the variable ranges and then the default type.
- R7: Range k matches when its valid bit is set and (addr & mask) equals (base & mask) over bits [35:12]. With no match, the default type bits [7:0] apply.
- R8: Among several matches, a type 0 match wins. Otherwise a type 4 match wins. Otherwise the type of the lowest-numbered matching range is used.
- R9: `memType` is registered. The value seen after a rising edge is resolved from the address and the register contents as they stood before that edge.
- R10: `cfgMalformed` is 1 when any valid range has a mask whose inverse over [35:12] is not a run of low ones, or a base that has a bit set inside that inverse.
- R11: `cfgConflict` is 1 when two valid ranges overlap and their types are neither equal nor the pair {0, 6}. Two ranges overlap when (baseA ^ baseB) & maskA & maskB is zero over [35:12].
- R12: Writes to indices that R3 does not map (13 to 15, and beyond the last mask) change nothing, and those indices read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | IDX_W | Register index for the write |
| wrData | input | 64 | Write data |
| rdIdx | input | IDX_W | Register index for the combinational read |
| rdData | output | 64 | Read data for `rdIdx` |
| physAddr | input | 36 | Physical address to resolve |
| memType | output | 8 | Resolved memory type, one cycle after the address |
| cfgMalformed | output | 1 | Some valid variable range has an illegal shape |
| cfgConflict | output | 1 | Two valid variable ranges overlap with incompatible types |

## Verification
The bench builds the block with NUM_VAR=4 and FIX_SUP=1, so the index field is five bits wide and the variable words sit at indices 16 to 23. Four ranges are enough to stack an uncacheable hit, a write-through hit, a write-back hit and a write-combining hit on one address, which exercises every branch of the precedence rule and the pairwise conflict search. Because the fixed bank is present, both the fixed-enable path and the path where low addresses fall through to the variable ranges can be reached.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  localparam logic [7:0] TY_UC = 8'd0;
  localparam logic [7:0] TY_WT = 8'd4;
  localparam logic [7:0] TY_WB = 8'd6;

  localparam int FIX_REGS = 11;          // 88 one-byte regions, eight per word
  localparam int FIX_BASE = 2;           // first fixed word index
  localparam int VAR_BASE = 16;          // first variable base word index
  localparam int SEL_W    = 4;           // up to 16 fixed or variable selects

  localparam logic [63:0] DEF_KEEP  = 64'h0000_0000_0000_0CFF;
  localparam logic [63:0] BASE_KEEP = 64'h0000_000F_FFFF_F0FF;
  localparam logic [63:0] MASK_KEEP = 64'h0000_000F_FFFF_F800;

  typedef struct packed {
    logic             wrDef;
    logic             wrFix;
    logic             wrBase;
    logic             wrMask;
    logic [SEL_W-1:0] sel;
  } wrStrobe_t;

  function automatic logic typesCompatible(input logic [7:0] a, input logic [7:0] b);
    return (a == b) || (a == TY_UC && b == TY_WB) || (a == TY_WB && b == TY_UC);
  endfunction

endpackage

// File: rtl/mtr_ctrl.sv
module mtr_ctrl
  import mtr_pkg::*;
#(
  parameter int NUM_VAR = 8,
  parameter int IDX_W   = 5
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  output wrStrobe_t        stb
);

  localparam int VAR_END = VAR_BASE + 2 * NUM_VAR;

  always_comb begin
    int idx;
    idx = int'(wrIdx);
    stb = '0;
    if (wrEn) begin
      if (idx == 1) begin
        stb.wrDef = 1'b1;
      end else if (idx >= FIX_BASE && idx < FIX_BASE + FIX_REGS) begin
        stb.wrFix = 1'b1;
        stb.sel   = SEL_W'(idx - FIX_BASE);
      end else if (idx >= VAR_BASE && idx < VAR_END) begin
        stb.sel    = SEL_W'((idx - VAR_BASE) >> 1);
        stb.wrMask = wrIdx[0];
        stb.wrBase = ~wrIdx[0];
      end
    end
  end

endmodule

// File: rtl/mtr_datapath.sv
module mtr_datapath
  import mtr_pkg::*;
#(
  parameter int NUM_VAR = 8,
  parameter bit FIX_SUP = 1'b1,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        stb,
  input  logic [63:0]      wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [63:0]      rdData,
  input  logic [35:0]      physAddr,
  output logic [7:0]       memType,
  output logic             cfgMalformed,
  output logic             cfgConflict
);

  localparam int VAR_END = VAR_BASE + 2 * NUM_VAR;
  localparam logic [63:0] CAP_WORD = {55'd0, FIX_SUP, 8'(NUM_VAR)};

  logic [63:0] defReg;
  logic [63:0] fixReg  [FIX_REGS];
  logic [63:0] varBase [NUM_VAR];
  logic [63:0] varMask [NUM_VAR];
  logic [FIX_REGS*64-1:0] fixFlat;
  logic [7:0] resolved;

  // register file and output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defReg  <= '0;
      memType <= TY_UC;
      for (int i = 0; i < FIX_REGS; i++) fixReg[i] <= '0;
      for (int k = 0; k < NUM_VAR; k++) begin
        varBase[k] <= '0;
        varMask[k] <= '0;
      end
    end else begin
      memType <= resolved;
      if (stb.wrDef) defReg <= wrData & DEF_KEEP;
      for (int i = 0; i < FIX_REGS; i++)
        if (stb.wrFix && stb.sel == SEL_W'(i)) fixReg[i] <= wrData;
      for (int k = 0; k < NUM_VAR; k++) begin
        if (stb.wrBase && stb.sel == SEL_W'(k)) varBase[k] <= wrData & BASE_KEEP;
        if (stb.wrMask && stb.sel == SEL_W'(k)) varMask[k] <= wrData & MASK_KEEP;
      end
    end
  end

  always_comb
    for (int i = 0; i < FIX_REGS; i++) fixFlat[i*64 +: 64] = fixReg[i];

  // fixed-bank region lookup
  logic [6:0] fixPos;
  logic [7:0] fixByte;
  logic       isLow;

  always_comb begin
    if (!physAddr[19])      fixPos = {4'd0, physAddr[18:16]};
    else if (!physAddr[18]) fixPos = 7'd8 + {3'd0, physAddr[17:14]};
    else                    fixPos = 7'd24 + {1'b0, physAddr[17:12]};
  end
  assign fixByte = fixFlat[int'(fixPos)*8 +: 8];
  assign isLow   = (physAddr[35:20] == '0);

  // per-range match, shape and pairwise overlap checks
  logic [NUM_VAR-1:0]         hit;
  logic [NUM_VAR-1:0]         badShape;
  logic [NUM_VAR*NUM_VAR-1:0] pairBad;

  for (genvar k = 0; k < NUM_VAR; k++) begin : g_range
    logic [23:0] inv;
    assign inv = ~varMask[k][35:12];
    assign hit[k] = varMask[k][11] &&
                    (((physAddr[35:12] ^ varBase[k][35:12]) & varMask[k][35:12]) == '0);
    assign badShape[k] = varMask[k][11] &&
                         (((inv & (inv + 24'd1)) != '0) || ((varBase[k][35:12] & inv) != '0));
    for (genvar j = 0; j < NUM_VAR; j++) begin : g_pair
      if (j > k) begin : g_upper
        assign pairBad[k*NUM_VAR+j] = varMask[k][11] && varMask[j][11] &&
            (((varBase[k][35:12] ^ varBase[j][35:12]) & varMask[k][35:12] & varMask[j][35:12]) == '0) &&
            !typesCompatible(varBase[k][7:0], varBase[j][7:0]);
      end else begin : g_lower
        assign pairBad[k*NUM_VAR+j] = 1'b0;
      end
    end
  end

  assign cfgMalformed = |badShape;
  assign cfgConflict  = |pairBad;

  // precedence among variable hits
  logic       anyUc, anyWt, found;
  logic [7:0] firstTy;

  always_comb begin
    anyUc   = 1'b0;
    anyWt   = 1'b0;
    found   = 1'b0;
    firstTy = TY_UC;
    for (int k = NUM_VAR - 1; k >= 0; k--) begin
      if (hit[k]) begin
        found   = 1'b1;
        firstTy = varBase[k][7:0];
        if (varBase[k][7:0] == TY_UC) anyUc = 1'b1;
        if (varBase[k][7:0] == TY_WT) anyWt = 1'b1;
      end
    end
  end

  always_comb begin
    if (!defReg[11])                       resolved = TY_UC;
    else if (FIX_SUP && defReg[10] && isLow) resolved = fixByte;
    else if (anyUc)                        resolved = TY_UC;
    else if (anyWt)                        resolved = TY_WT;
    else if (found)                        resolved = firstTy;
    else                                   resolved = defReg[7:0];
  end

  // combinational read port
  always_comb begin
    int ri;
    int rk;
    ri = int'(rdIdx);
    rk = (ri - VAR_BASE) >> 1;
    rdData = '0;
    if (ri == 0)
      rdData = CAP_WORD;
    else if (ri == 1)
      rdData = defReg;
    else if (ri >= FIX_BASE && ri < FIX_BASE + FIX_REGS)
      rdData = fixFlat[(ri-FIX_BASE)*64 +: 64];
    else if (ri >= VAR_BASE && ri < VAR_END)
      rdData = rdIdx[0] ? varMask[rk] : varBase[rk];
  end

endmodule

// File: rtl/mtr_unit.sv
module mtr_unit
  import mtr_pkg::*;
#(
  parameter int NUM_VAR = 8,
  parameter bit FIX_SUP = 1'b1,
  localparam int IDX_W  = $clog2(VAR_BASE + 2 * NUM_VAR)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [63:0]      wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [63:0]      rdData,
  input  logic [35:0]      physAddr,
  output logic [7:0]       memType,
  output logic             cfgMalformed,
  output logic             cfgConflict
);

  wrStrobe_t wrStb;

  mtr_ctrl #(.NUM_VAR(NUM_VAR), .IDX_W(IDX_W)) u_ctrl (
    .wrEn  (wrEn),
    .wrIdx (wrIdx),
    .stb   (wrStb)
  );

  mtr_datapath #(.NUM_VAR(NUM_VAR), .FIX_SUP(FIX_SUP), .IDX_W(IDX_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (wrStb),
    .wrData       (wrData),
    .rdIdx        (rdIdx),
    .rdData       (rdData),
    .physAddr     (physAddr),
    .memType      (memType),
    .cfgMalformed (cfgMalformed),
    .cfgConflict  (cfgConflict)
  );

endmodule

// File: rtl/mtr_unit_checks.sv
module mtr_unit_checks #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrIdx,
  input logic [63:0]      wrData,
  input logic [35:0]      physAddr,
  input logic [7:0]       memType,
  input logic             globalEn,
  input logic [7:0]       defType,
  input logic [3:0]       stbFlags
);

  // R4: a cleared global enable forces uncacheable on the next output
  a_r4_disabled_uc: assert property (@(posedge clk) disable iff (!rstN)
    !$past(globalEn) |-> memType == 8'd0);

  // R3: a default-word write lands in the register on the next edge
  a_r3_def_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == IDX_W'(1)) |=> (globalEn == $past(wrData[11]) && defType == $past(wrData[7:0])));

  // R3: the decoder raises at most one register strobe
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbFlags));

  // R12: no strobe without a write request
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> stbFlags == 4'd0);

  // R9: a held address with no write in between keeps the output steady
  a_r9_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn, 2) && $past(physAddr) == $past(physAddr, 2)) |-> $stable(memType));

endmodule

bind mtr_unit mtr_unit_checks #(.IDX_W(IDX_W)) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrIdx    (wrIdx),
  .wrData   (wrData),
  .physAddr (physAddr),
  .memType  (memType),
  .globalEn (u_dp.defReg[11]),
  .defType  (u_dp.defReg[7:0]),
  .stbFlags ({u_dp.stb.wrDef, u_dp.stb.wrFix, u_dp.stb.wrBase, u_dp.stb.wrMask})
);

// File: tb/mtr_unit_test.sv
`timescale 1ns/1ps
module mtr_unit_test;

  localparam int NV = 4;
  localparam bit FS = 1'b1;
  localparam int IW = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [IW-1:0] wrIdx = '0;
  logic [63:0] wrData = '0;
  logic [IW-1:0] rdIdx = '0;
  logic [63:0] rdData;
  logic [35:0] physAddr = '0;
  logic [7:0]  memType;
  logic        cfgMalformed, cfgConflict;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  mtr_unit #(.NUM_VAR(NV), .FIX_SUP(FS)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .physAddr(physAddr), .memType(memType),
    .cfgMalformed(cfgMalformed), .cfgConflict(cfgConflict)
  );

  // ---------------- reference model ----------------
  logic [63:0] mDef;
  logic [63:0] mFix [11];
  logic [63:0] mBase [NV];
  logic [63:0] mMask [NV];

  task automatic modelReset();
    mDef = '0;
    for (int i = 0; i < 11; i++) mFix[i] = '0;
    for (int k = 0; k < NV; k++) begin mBase[k] = '0; mMask[k] = '0; end
  endtask

  task automatic modelWrite(input int idx, input logic [63:0] d);
    if (idx == 1) mDef = d & 64'hCFF;
    else if (idx >= 2 && idx <= 12) mFix[idx-2] = d;
    else if (idx >= 16 && idx < 16 + 2*NV) begin
      if (idx % 2 == 1) mMask[(idx-16)/2] = d & 64'hF_FFFF_F800;
      else              mBase[(idx-16)/2] = d & 64'hF_FFFF_F0FF;
    end
  endtask

  function automatic logic [63:0] modelRead(input int idx);
    if (idx == 0) return 64'(NV) + (FS ? 64'h100 : 64'h0);
    if (idx == 1) return mDef;
    if (idx >= 2 && idx <= 12) return mFix[idx-2];
    if (idx >= 16 && idx < 16 + 2*NV)
      return (idx % 2 == 1) ? mMask[(idx-16)/2] : mBase[(idx-16)/2];
    return 64'h0;
  endfunction

  function automatic logic [7:0] modelResolve(input logic [35:0] a);
    longint av;
    int r;
    int hits;
    bit uc, wt;
    logic [7:0] first;
    av = longint'(a);
    if (!mDef[11]) return 8'd0;
    if (FS && mDef[10] && av < 64'h100000) begin
      if (av < 64'h80000) r = int'(av / 64'h10000);
      else if (av < 64'hC0000) r = 8 + int'((av - 64'h80000) / 64'h4000);
      else r = 24 + int'((av - 64'hC0000) / 64'h1000);
      return mFix[r/8][8*(r%8) +: 8];
    end
    hits = 0; uc = 0; wt = 0; first = 8'd0;
    for (int k = 0; k < NV; k++) begin
      longint m;
      m = longint'(mMask[k][35:12]) << 12;
      if (mMask[k][11] && ((av & m) == (longint'(mBase[k][35:12] << 12) & m))) begin
        if (hits == 0) first = mBase[k][7:0];
        hits++;
        if (mBase[k][7:0] == 8'd0) uc = 1;
        if (mBase[k][7:0] == 8'd4) wt = 1;
      end
    end
    if (uc) return 8'd0;
    if (wt) return 8'd4;
    if (hits > 0) return first;
    return mDef[7:0];
  endfunction

  function automatic bit modelMalformed();
    for (int k = 0; k < NV; k++) begin
      longint len, b;
      if (!mMask[k][11]) continue;
      len = ((~longint'(mMask[k][35:0] & 36'hF_FFFF_F000)) & 64'hF_FFFF_FFFF) + 1;
      b = longint'(mBase[k][35:12]) << 12;
      if ((len & (len - 1)) != 0) return 1;
      if ((b & (len - 1)) != 0) return 1;
    end
    return 0;
  endfunction

  function automatic bit modelConflict();
    for (int i = 0; i < NV; i++)
      for (int j = i + 1; j < NV; j++) begin
        logic [7:0] ti, tj;
        bit ok;
        if (!(mMask[i][11] && mMask[j][11])) continue;
        if (((mBase[i][35:12] ^ mBase[j][35:12]) & mMask[i][35:12] & mMask[j][35:12]) != 0) continue;
        ti = mBase[i][7:0]; tj = mBase[j][7:0];
        ok = (ti == tj) || (ti + tj == 8'd6 && (ti == 8'd0 || tj == 8'd0));
        if (!ok) return 1;
      end
    return 0;
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  // one clock: inputs applied at a falling edge, results compared at the next one
  task automatic cyc(input bit we, input int idx, input logic [63:0] d, input logic [35:0] a, input int rd);
    logic [7:0] pend;
    wrEn = we; wrIdx = IW'(idx); wrData = d; physAddr = a; rdIdx = IW'(rd);
    pend = modelResolve(a);
    @(negedge clk);
    if (we) modelWrite(idx, d);
    chk(tag, "memType", 64'(memType), 64'(pend));
    chk(tag, "rdData", rdData, modelRead(rd));
    chk("R10", "cfgMalformed", 64'(cfgMalformed), 64'(modelMalformed()));
    chk("R11", "cfgConflict", 64'(cfgConflict), 64'(modelConflict()));
  endtask

  task automatic wr(input int idx, input logic [63:0] d);
    cyc(1'b1, idx, d, 36'h0, idx);
  endtask

  task automatic probe(input logic [35:0] a, input logic [7:0] exp, input string t);
    cyc(1'b0, 0, 64'h0, a, 1);
    chk(t, "memType literal", 64'(memType), 64'(exp));
  endtask

  function automatic logic [7:0] patType(input int n);
    case (n % 5)
      0: return 8'd0;
      1: return 8'd1;
      2: return 8'd4;
      3: return 8'd5;
      default: return 8'd6;
    endcase
  endfunction

  initial begin
    #(4 * 190000);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    chk("R1", "memType in reset", 64'(memType), 64'h0);
    rstN = 1'b1;

    // R1: reset values
    tag = "R1";
    cyc(0, 0, 0, 36'h12345000, 1);
    cyc(0, 0, 0, 36'h00001000, 2);
    cyc(0, 0, 0, 36'h0, 16);
    cyc(0, 0, 0, 36'h0, 17);
    chk("R1", "malformed after reset", 64'(cfgMalformed), 64'h0);

    // R2: capability word, writes ignored
    tag = "R2";
    wr(0, 64'hFFFF_FFFF_FFFF_FFFF);
    cyc(0, 0, 0, 36'h0, 0);
    chk("R2", "capability", rdData, 64'h104);

    // R3 and R9: default word masking, same-cycle write and address
    tag = "R9";
    cyc(1, 1, 64'hFFFF_0000_0000_F806, 36'h8_0000_0000, 1);
    chk("R9", "old state used", 64'(memType), 64'h0);
    cyc(0, 0, 0, 36'h8_0000_0000, 1);
    chk("R9", "new state used", 64'(memType), 64'h6);
    chk("R3", "default keep mask", rdData, 64'h806);

    // R5: fixed bank pattern
    tag = "R5";
    for (int i = 0; i < 11; i++) begin
      logic [63:0] w;
      for (int j = 0; j < 8; j++) w[8*j +: 8] = patType(i + j);
      wr(2 + i, w);
    end
    wr(1, 64'hC05);
    probe(36'h00000, 8'd0, "R5");
    probe(36'h30000, 8'd5, "R5");
    probe(36'h84000, 8'd4, "R5");
    probe(36'hC0000, 8'd5, "R5");
    probe(36'hFF000, 8'd4, "R5");
    for (int r = 0; r < 88; r++) begin
      int base;
      if (r < 8) base = r * 'h10000;
      else if (r < 24) base = 'h80000 + (r - 8) * 'h4000;
      else base = 'hC0000 + (r - 24) * 'h1000;
      cyc(0, 0, 0, 36'(base), 2 + (r % 11));
      cyc(0, 0, 0, 36'(base + 'hFFF), 2);
    end
    probe(36'h100000, 8'd5, "R5");

    // R6: fixed enable clear, low addresses fall through
    tag = "R6";
    wr(1, 64'h805);
    probe(36'h30000, 8'd5, "R6");
    probe(36'hFF000, 8'd5, "R6");

    // R7 / R8 / R10 / R11: variable ranges
    tag = "R7";
    wr(16, 64'h0_0010_0006);
    wr(17, 64'hF_FFF0_0800);
    probe(36'h150000, 8'd6, "R7");
    probe(36'h800000, 8'd5, "R7");
    tag = "R8";
    wr(18, 64'h0_0018_0000);
    wr(19, 64'hF_FFF8_0800);
    chk("R11", "WB with UC allowed", 64'(cfgConflict), 64'h0);
    probe(36'h1C0000, 8'd0, "R8");
    wr(20, 64'h0_0010_0004);
    wr(21, 64'hF_FFFC_0800);
    chk("R11", "WT over WB conflict", 64'(cfgConflict), 64'h1);
    probe(36'h100010, 8'd4, "R8");
    wr(22, 64'h0_0010_0001);
    wr(23, 64'hF_FFFF_F800);
    probe(36'h100000, 8'd4, "R8");
    wr(21, 64'h0);
    probe(36'h100000, 8'd6, "R8");
    tag = "R6";
    probe(36'h30000, 8'd5, "R6");

    tag = "R10";
    wr(23, 64'hF_FFFF_5800);
    chk("R10", "non-contiguous mask", 64'(cfgMalformed), 64'h1);
    wr(23, 64'hF_FFFF_E800);
    wr(22, 64'h0_0040_1001);
    chk("R10", "misaligned base", 64'(cfgMalformed), 64'h1);
    wr(22, 64'h0_0040_0001);
    chk("R10", "well formed", 64'(cfgMalformed), 64'h0);

    // R12: unmapped indices
    tag = "R12";
    wr(13, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(15, 64'hFFFF_FFFF_FFFF_FFFF);
    cyc(0, 0, 0, 36'h400000, 13);
    chk("R12", "unmapped read", rdData, 64'h0);
    probe(36'h400000, 8'd1, "R12");

    // R4: global enable clear
    tag = "R4";
    wr(1, 64'h406);
    probe(36'h1C0000, 8'd0, "R4");
    probe(36'h400000, 8'd0, "R4");
    probe(36'h30000, 8'd0, "R4");

    // mixed random traffic against the model
    tag = "R7";
    for (int n = 0; n < 600; n++) begin
      int idx;
      logic [63:0] d;
      logic [35:0] a;
      bit we;
      we = ($urandom % 3) == 0;
      idx = int'($urandom % 24);
      d = {$urandom, $urandom};
      if (idx == 1) d[11] = ($urandom % 4) != 0;
      if (idx >= 16 && idx % 2 == 1 && ($urandom % 2) == 1)
        d[35:12] = 24'hFFFFFF << ($urandom % 12);
      d[7:0] = patType(int'($urandom % 5));
      if (($urandom % 2) == 1) a = 36'($urandom % 32'h100000);
      else a = {4'($urandom), $urandom};
      cyc(we, idx, d, a, int'($urandom % 24));
    end

    finished = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule